// File: doc/BRIEF.md
# Receive Destination Address Screen

This block watches the byte stream of an incoming Ethernet frame and decides from its first six bytes whether the frame is addressed to this station. The stream carries one byte per cycle with a valid strobe, a start-of-frame strobe on the first byte and an end-of-frame strobe on the last byte. The decision is produced once per frame as a single-cycle accept or drop pulse. A separate single-cycle pulse flags frames that end before twelve bytes have arrived.

Four tests can admit a frame: an exact match against either of two programmable station addresses, a broadcast test, and a group test through a 64-entry single-hash table. Each test other than the group test has its own enable bit. The group test normally applies only to multicast destinations and can be widened to all destinations. The settings live in seven 32-bit registers behind a simple write strobe and a combinational read port. The hash is built up byte by byte, so the block holds no copy of the destination address.

Top module: `dest_addr_screen`

## Requirements
- R1: After reset, `dec_accept`, `dec_drop` and `short_frame` are low, and every register reads back as zero.
- R2: Register offsets on `cfg_addr`: 0 control (bits 3:0 used), 1 and 2 station address A low and high, 3 and 4 station address B low and high, 5 and 6 group table low and high. A low address register holds destination bytes 0 to 3 with byte 0 in bits 7:0. A high address register keeps only bits 15:0 (bytes 4 and 5) and reads zero above them.
- R3: With control bit 0 set, a destination equal to station address A is accepted. With bit 0 clear, address A admits nothing. A mismatch in any byte, including the last, is not a match.
- R4: With control bit 1 set, a destination equal to station address B is accepted.
- R5: With control bit 3 set, the destination FF:FF:FF:FF:FF:FF is accepted.
- R6: The group index is the XOR of the eight 6-bit slices of the destination, taken as a 48-bit value with the first byte in bits 7:0. An index of 32 or more selects bit (index-32) of the table high register. A smaller index selects that bit of the table low register. A set bit admits the frame.
- R7: The group table applies only when bit 0 of the first destination byte is 1. When control bit 2 is set, it applies to every destination.
- R8: Each frame of six or more bytes gives exactly one pulse, either `dec_accept` or `dec_drop`, and never both. The pulse comes in the cycle after the sixth byte is taken.
- R9: A frame whose end-of-frame byte is taken with fewer than 12 bytes in total raises `short_frame` for the cycle after that byte. A frame of 12 bytes or more does not. A frame shorter than six bytes gives no accept or drop pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register offset |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data (combinational) |
| rx_valid | input | 1 | Byte strobe |
| rx_sof | input | 1 | First byte of frame |
| rx_eof | input | 1 | Last byte of frame |
| rx_byte | input | 8 | Frame byte |
| dec_accept | output | 1 | Frame admitted pulse |
| dec_drop | output | 1 | Frame rejected pulse |
| short_frame | output | 1 | Frame shorter than 12 bytes pulse |

## Verification
Faults inside the block show up at the ports only within one frame. A wrong hash accumulation or phase shows as a wrong accept or drop for a multicast frame whose table bit is known. A stale per-byte compare flag shows as a false accept for an address that differs only in its last byte. A wrong byte count shows either as a decision pulse outside the cycle after the sixth byte or as a short-frame pulse at the wrong length. All of these appear at most one cycle after the byte that causes them. The bench therefore records the sample position of every pulse as well as its count.

// File: rtl/rdf_pkg.sv
package rdf_pkg;
  localparam int DA_BYTES  = 6;
  localparam int HASH_W    = 6;
  localparam int TABLE_LEN = 1 << HASH_W;
  localparam int DA_W      = DA_BYTES * 8;

  localparam logic [2:0] OFS_CTRL  = 3'd0;
  localparam logic [2:0] OFS_A_LO  = 3'd1;
  localparam logic [2:0] OFS_A_HI  = 3'd2;
  localparam logic [2:0] OFS_B_LO  = 3'd3;
  localparam logic [2:0] OFS_B_HI  = 3'd4;
  localparam logic [2:0] OFS_G_LO  = 3'd5;
  localparam logic [2:0] OFS_G_HI  = 3'd6;

  typedef struct packed {
    logic                 bcast_en;
    logic                 hash_all;
    logic                 stn_b_en;
    logic                 stn_a_en;
  } ctrl_t;

  typedef struct packed {
    ctrl_t                ctrl;
    logic [DA_W-1:0]      stn_a;
    logic [DA_W-1:0]      stn_b;
    logic [TABLE_LEN-1:0] grp;
  } screen_cfg_t;
endpackage

// File: rtl/rdf_cfg_regs.sv
module rdf_cfg_regs
  import rdf_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [2:0]        addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  output screen_cfg_t       cfg
);
  localparam int HI_W = DA_W - 32;

  logic [3:0]      ctrl_q, ctrl_d;
  logic [31:0]     a_lo_q, a_lo_d, b_lo_q, b_lo_d;
  logic [HI_W-1:0] a_hi_q, a_hi_d, b_hi_q, b_hi_d;
  logic [31:0]     g_lo_q, g_lo_d, g_hi_q, g_hi_d;

  always_comb begin
    ctrl_d = ctrl_q;
    a_lo_d = a_lo_q;
    a_hi_d = a_hi_q;
    b_lo_d = b_lo_q;
    b_hi_d = b_hi_q;
    g_lo_d = g_lo_q;
    g_hi_d = g_hi_q;
    if (we) begin
      case (addr)
        OFS_CTRL: ctrl_d = wdata[3:0];
        OFS_A_LO: a_lo_d = wdata;
        OFS_A_HI: a_hi_d = wdata[HI_W-1:0];
        OFS_B_LO: b_lo_d = wdata;
        OFS_B_HI: b_hi_d = wdata[HI_W-1:0];
        OFS_G_LO: g_lo_d = wdata;
        OFS_G_HI: g_hi_d = wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      a_lo_q <= '0;
      a_hi_q <= '0;
      b_lo_q <= '0;
      b_hi_q <= '0;
      g_lo_q <= '0;
      g_hi_q <= '0;
    end else if (we) begin
      ctrl_q <= ctrl_d;
      a_lo_q <= a_lo_d;
      a_hi_q <= a_hi_d;
      b_lo_q <= b_lo_d;
      b_hi_q <= b_hi_d;
      g_lo_q <= g_lo_d;
      g_hi_q <= g_hi_d;
    end
  end

  always_comb begin
    case (addr)
      OFS_CTRL: rdata = {28'd0, ctrl_q};
      OFS_A_LO: rdata = a_lo_q;
      OFS_A_HI: rdata = {{(32-HI_W){1'b0}}, a_hi_q};
      OFS_B_LO: rdata = b_lo_q;
      OFS_B_HI: rdata = {{(32-HI_W){1'b0}}, b_hi_q};
      OFS_G_LO: rdata = g_lo_q;
      OFS_G_HI: rdata = g_hi_q;
      default:  rdata = '0;
    endcase
  end

  assign cfg.ctrl  = ctrl_t'(ctrl_q);
  assign cfg.stn_a = {a_hi_q, a_lo_q};
  assign cfg.stn_b = {b_hi_q, b_lo_q};
  assign cfg.grp   = {g_hi_q, g_lo_q};
endmodule

// File: rtl/rdf_hash_acc.sv
module rdf_hash_acc #(
  parameter int HASH_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              byte_en,
  input  logic              first,
  input  logic [7:0]        byte_in,
  output logic [HASH_W-1:0] hash_now
);
  localparam int PH_W = $clog2(HASH_W);
  localparam int STEP = 8 % HASH_W;

  logic [HASH_W-1:0] acc_q, acc_d;
  logic [PH_W-1:0]   ph_q, ph_d;
  logic [PH_W-1:0]   ph_use;
  logic [HASH_W-1:0] base;

  function automatic logic [HASH_W-1:0] fold(input logic [7:0] b,
                                             input logic [PH_W-1:0] off);
    logic [HASH_W-1:0] r;
    r = '0;
    for (int k = 0; k < 8; k++) begin
      r[(int'(off) + k) % HASH_W] = r[(int'(off) + k) % HASH_W] ^ b[k];
    end
    return r;
  endfunction

  always_comb begin
    ph_use   = first ? '0 : ph_q;
    base     = first ? '0 : acc_q;
    hash_now = base ^ fold(byte_in, ph_use);
    acc_d    = hash_now;
    ph_d     = PH_W'((int'(ph_use) + STEP) % HASH_W);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      ph_q  <= '0;
    end else if (byte_en) begin
      acc_q <= acc_d;
      ph_q  <= ph_d;
    end
  end
endmodule

// File: rtl/rdf_byte_cmp.sv
module rdf_byte_cmp #(
  parameter int NBYTES = 6,
  parameter int IDX_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              byte_en,
  input  logic              first,
  input  logic [IDX_W-1:0]  idx,
  input  logic [7:0]        byte_in,
  input  logic [NBYTES*8-1:0] ref_addr,
  output logic              match_now
);
  logic [NBYTES-1:0][7:0] ref_bytes;
  logic eq_q, eq_d;
  logic same;

  assign ref_bytes = ref_addr;

  always_comb begin
    same      = (int'(idx) < NBYTES) && (ref_bytes[idx] == byte_in);
    match_now = (first || eq_q) && same;
    eq_d      = match_now;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) eq_q <= 1'b0;
    else if (byte_en) eq_q <= eq_d;
  end
endmodule

// File: rtl/dest_addr_screen.sv
module dest_addr_screen
  import rdf_pkg::*;
#(
  parameter int RUNT_LEN = 12
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_we,
  input  logic [2:0]  cfg_addr,
  input  logic [31:0] cfg_wdata,
  output logic [31:0] cfg_rdata,
  input  logic        rx_valid,
  input  logic        rx_sof,
  input  logic        rx_eof,
  input  logic [7:0]  rx_byte,
  output logic        dec_accept,
  output logic        dec_drop,
  output logic        short_frame
);
  localparam int CNT_W = $clog2(RUNT_LEN + 1);
  localparam int IDX_W = $clog2(DA_BYTES);
  localparam int NCMP  = 3;

  screen_cfg_t cfg;
  logic [3:0]           ctrl_w;
  logic [TABLE_LEN-1:0] table_w;

  logic [CNT_W-1:0] cnt_q, cnt_d, idx;
  logic             in_frame_q, in_frame_d;
  logic             mcast_q, mcast_d;
  logic             take, da_en, dec_now, mcast_now;
  logic [HASH_W-1:0] hash_now;
  logic [NCMP-1:0]  cmp_hit;
  logic [NCMP-1:0][DA_W-1:0] cmp_ref;
  logic             acc_d, drop_d, runt_d;
  logic             acc_q, drop_q, runt_q;
  logic             hash_hit, admit;

  rdf_cfg_regs u_regs (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (cfg_we),
    .addr  (cfg_addr),
    .wdata (cfg_wdata),
    .rdata (cfg_rdata),
    .cfg   (cfg)
  );

  assign ctrl_w  = cfg.ctrl;
  assign table_w = cfg.grp;

  assign idx   = rx_sof ? '0 : cnt_q;
  assign take  = rx_valid && (rx_sof || in_frame_q);
  assign da_en = take && (int'(idx) < DA_BYTES);

  rdf_hash_acc #(.HASH_W(HASH_W)) u_hash (
    .clk      (clk),
    .rst_n    (rst_n),
    .byte_en  (da_en),
    .first    (rx_sof),
    .byte_in  (rx_byte),
    .hash_now (hash_now)
  );

  assign cmp_ref[0] = cfg.stn_a;
  assign cmp_ref[1] = cfg.stn_b;
  assign cmp_ref[2] = '1;

  for (genvar g = 0; g < NCMP; g++) begin : g_cmp
    rdf_byte_cmp #(.NBYTES(DA_BYTES), .IDX_W(IDX_W)) u_cmp (
      .clk       (clk),
      .rst_n     (rst_n),
      .byte_en   (da_en),
      .first     (rx_sof),
      .idx       (idx[IDX_W-1:0]),
      .byte_in   (rx_byte),
      .ref_addr  (cmp_ref[g]),
      .match_now (cmp_hit[g])
    );
  end

  always_comb begin
    cnt_d      = cnt_q;
    in_frame_d = in_frame_q;
    mcast_d    = mcast_q;
    if (take) begin
      cnt_d = (int'(idx) >= RUNT_LEN) ? CNT_W'(RUNT_LEN) : idx + 1'b1;
      if (rx_sof) mcast_d = rx_byte[0];
      in_frame_d = !rx_eof;
    end
    mcast_now = rx_sof ? rx_byte[0] : mcast_q;
    dec_now   = take && (int'(idx) == DA_BYTES - 1);
    hash_hit  = (cfg.ctrl.hash_all || mcast_now) && table_w[hash_now];
    admit     = (cfg.ctrl.stn_a_en && cmp_hit[0])
             || (cfg.ctrl.stn_b_en && cmp_hit[1])
             || (cfg.ctrl.bcast_en && cmp_hit[2])
             || hash_hit;
    acc_d     = dec_now && admit;
    drop_d    = dec_now && !admit;
    runt_d    = take && rx_eof && (int'(idx) < RUNT_LEN - 1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q      <= '0;
      in_frame_q <= 1'b0;
      mcast_q    <= 1'b0;
      acc_q      <= 1'b0;
      drop_q     <= 1'b0;
      runt_q     <= 1'b0;
    end else begin
      cnt_q      <= cnt_d;
      in_frame_q <= in_frame_d;
      mcast_q    <= mcast_d;
      acc_q      <= acc_d;
      drop_q     <= drop_d;
      runt_q     <= runt_d;
    end
  end

  assign dec_accept  = acc_q;
  assign dec_drop    = drop_q;
  assign short_frame = runt_q;
endmodule

// File: rtl/rdf_checker.sv
module rdf_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        rx_valid,
  input logic        rx_eof,
  input logic        dec_accept,
  input logic        dec_drop,
  input logic        short_frame,
  input logic [3:0]  ctrl_w,
  input logic [63:0] table_w
);
  // R8
  one_verdict_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(dec_accept && dec_drop));

  // R8
  verdict_after_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_accept || dec_drop) |-> $past(rx_valid));

  // R8
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_accept || dec_drop) |=> !(dec_accept || dec_drop));

  // R9
  runt_after_eof_chk: assert property (@(posedge clk) disable iff (!rst_n)
    short_frame |-> $past(rx_valid && rx_eof));

  // R3
  accept_needs_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dec_accept |-> $past(ctrl_w != 4'd0 || table_w != 64'd0));
endmodule

bind dest_addr_screen rdf_checker u_rdf_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .rx_valid    (rx_valid),
  .rx_eof      (rx_eof),
  .dec_accept  (dec_accept),
  .dec_drop    (dec_drop),
  .short_frame (short_frame),
  .ctrl_w      (ctrl_w),
  .table_w     (table_w)
);

// File: tb/test_dest_addr_screen.sv
module test_dest_addr_screen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        rx_valid = 1'b0;
  logic        rx_sof = 1'b0;
  logic        rx_eof = 1'b0;
  logic [7:0]  rx_byte = '0;
  logic        dec_accept, dec_drop, short_frame;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  int acc_n, drop_n, runt_n, acc_pos, drop_pos, runt_pos;

  always #5 clk = ~clk;

  dest_addr_screen i_dest_addr_screen (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .rx_valid(rx_valid), .rx_sof(rx_sof), .rx_eof(rx_eof), .rx_byte(rx_byte),
    .dec_accept(dec_accept), .dec_drop(dec_drop), .short_frame(short_frame)
  );

  localparam logic [47:0] STN_A = 48'h0A09_0807_0602;
  localparam logic [47:0] STN_B = 48'h1E1D_1C1B_1A18;

  // {ctrl, table_full, destination (byte 0 in bits 7:0), expect_accept}
  localparam int NVEC = 12;
  localparam logic [53:0] VEC [NVEC] = '{
    {4'h1, 1'b0, STN_A,             1'b1},  // R3
    {4'h0, 1'b0, STN_A,             1'b0},  // R3 disabled
    {4'h2, 1'b0, STN_B,             1'b1},  // R4
    {4'h2, 1'b0, STN_A,             1'b0},  // R4 wrong slot
    {4'h1, 1'b0, 48'h0B09_0807_0602, 1'b0}, // R3 last byte differs
    {4'h8, 1'b0, 48'hFFFF_FFFF_FFFF, 1'b1}, // R5
    {4'h0, 1'b0, 48'hFFFF_FFFF_FFFF, 1'b0}, // R5 disabled, empty table
    {4'h0, 1'b1, 48'hFFFF_FFFF_FFFF, 1'b1}, // R7 multicast uses table
    {4'h0, 1'b1, STN_A,             1'b0},  // R7 unicast skips table
    {4'h4, 1'b1, STN_A,             1'b1},  // R7 hash on all
    {4'h3, 1'b0, STN_B,             1'b1},  // R4 both enabled
    {4'h8, 1'b0, 48'hFFFF_FFFF_FFFE, 1'b0}  // R5 not all ones
  };

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic cfg_read(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    cfg_addr = a;
    #1 d = cfg_rdata;
  endtask

  task automatic set_table(input logic [63:0] t);
    cfg_write(3'd5, t[31:0]);
    cfg_write(3'd6, t[63:32]);
  endtask

  task automatic send_frame(input logic [47:0] da, input int len);
    acc_n = 0; drop_n = 0; runt_n = 0;
    acc_pos = -1; drop_pos = -1; runt_pos = -1;
    for (int i = 0; i < len + 3; i++) begin
      @(negedge clk);
      if (dec_accept) begin acc_n++; acc_pos = i; end
      if (dec_drop) begin drop_n++; drop_pos = i; end
      if (short_frame) begin runt_n++; runt_pos = i; end
      if (i < len) begin
        rx_valid = 1'b1;
        rx_sof   = (i == 0);
        rx_eof   = (i == len - 1);
        rx_byte  = (i < 6) ? da[8*i +: 8] : 8'(8'hA0 + i);
      end else begin
        rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0; rx_byte = '0;
      end
    end
  endtask

  function automatic logic [5:0] ref_idx(input logic [47:0] da);
    logic [5:0] r = '0;
    for (int j = 0; j < 8; j++) r ^= da[6*j +: 6];
    return r;
  endfunction

  task automatic hash_case(input logic [47:0] da, input string tag);
    logic [5:0] hx;
    logic [63:0] bitv;
    hx = ref_idx(da);
    bitv = 64'd1 << hx;
    cfg_write(3'd0, 32'h0);
    set_table(bitv);
    send_frame(da, 16);
    chk(acc_n == 1 && drop_n == 0 && acc_pos == 6, tag, acc_n, 1);
    set_table(~bitv);
    send_frame(da, 16);
    chk(acc_n == 0 && drop_n == 1 && drop_pos == 6, tag, drop_n, 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    logic [47:0] da_lo, da_hi;
    bit got_lo, got_hi;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    @(negedge clk);
    chk(!dec_accept && !dec_drop && !short_frame, "R1 outputs", {dec_accept, dec_drop, short_frame}, 0);
    cfg_read(3'd0, rd); chk(rd == 0, "R1 ctrl", rd, 0);
    cfg_read(3'd6, rd); chk(rd == 0, "R1 table hi", rd, 0);

    // R2 register map and readback
    cfg_write(3'd2, 32'hFFFF_1234);
    cfg_read(3'd2, rd); chk(rd == 32'h0000_1234, "R2 hi width", rd, 32'h1234);
    cfg_write(3'd0, 32'hFFFF_FFF5);
    cfg_read(3'd0, rd); chk(rd == 32'h5, "R2 ctrl width", rd, 5);

    cfg_write(3'd1, STN_A[31:0]);
    cfg_write(3'd2, {16'h0, STN_A[47:32]});
    cfg_write(3'd3, STN_B[31:0]);
    cfg_write(3'd4, {16'h0, STN_B[47:32]});
    cfg_read(3'd3, rd); chk(rd == STN_B[31:0], "R2 B low", rd, STN_B[31:0]);

    // vector table: R3 R4 R5 R7 R8
    for (int v = 0; v < NVEC; v++) begin
      cfg_write(3'd0, {28'h0, VEC[v][53:50]});
      set_table(VEC[v][49] ? 64'hFFFF_FFFF_FFFF_FFFF : 64'h0);
      send_frame(VEC[v][48:1], 14);
      if (VEC[v][0])
        chk(acc_n == 1 && drop_n == 0 && acc_pos == 6, $sformatf("R8 vec%0d accept", v), acc_n, 1);
      else
        chk(acc_n == 0 && drop_n == 1 && drop_pos == 6, $sformatf("R8 vec%0d drop", v), drop_n, 1);
      chk(runt_n == 0, $sformatf("R9 vec%0d no short", v), runt_n, 0);
    end

    // R6 single table bit, both halves of the table
    got_lo = 0; got_hi = 0; da_lo = '0; da_hi = '0;
    for (int k = 1; k < 400; k++) begin
      logic [47:0] c;
      c = {32'(k * 40503), 8'h5E, 8'h01};
      if (ref_idx(c) < 32 && !got_lo) begin da_lo = c; got_lo = 1; end
      if (ref_idx(c) >= 32 && !got_hi) begin da_hi = c; got_hi = 1; end
    end
    hash_case(da_lo, "R6 low half");
    hash_case(da_hi, "R6 high half");

    // R7 unicast with only its table bit set needs control bit 2
    begin
      logic [47:0] u;
      u = {da_hi[47:8], 8'h5E};
      cfg_write(3'd0, 32'h0);
      set_table(64'd1 << ref_idx(u));
      send_frame(u, 14);
      chk(drop_n == 1 && acc_n == 0, "R7 unicast ignored", acc_n, 0);
      cfg_write(3'd0, 32'h4);
      send_frame(u, 14);
      chk(acc_n == 1 && acc_pos == 6, "R7 hash all", acc_n, 1);
    end

    // R9 short frames
    cfg_write(3'd0, 32'h1);
    set_table(64'h0);
    send_frame(STN_A, 8);
    chk(acc_n == 1 && acc_pos == 6, "R9 len8 verdict", acc_n, 1);
    chk(runt_n == 1 && runt_pos == 8, "R9 len8 short", runt_pos, 8);
    send_frame(STN_A, 11);
    chk(runt_n == 1 && runt_pos == 11, "R9 len11 short", runt_pos, 11);
    send_frame(STN_A, 12);
    chk(runt_n == 0, "R9 len12 not short", runt_n, 0);
    send_frame(STN_A, 4);
    chk(acc_n == 0 && drop_n == 0, "R9 len4 no verdict", acc_n + drop_n, 0);
    chk(runt_n == 1 && runt_pos == 4, "R9 len4 short", runt_pos, 4);

    finished = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule